// File: doc/BRIEF.md
# Linear and Device-Addressed Memory Access Port

This block is the backend memory port of a serial bus terminal. A host loads a 24-bit pointer, which is also readable, and then issues transfers one at a time. Each transfer reads from or writes to the location the pointer names. At the end of each linear transfer the pointer steps forward by one, so a block of words can be moved without reloading it. The pointer drives the address pins in every cycle. Read data arrives on one bus and write data leaves on a different bus.

A second kind of transfer targets devices that the user attaches outside the terminal. For these accesses a 10-bit device address is formed from a 5-bit sub-address and a 5-bit word number. The linear pointer is not used and does not change. Device transfers share the data buses and the two-cycle strobe timing of linear transfers. A separate select line tells the two kinds of target apart.

Top module: `xport`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears the pointer to 0. It also holds `busy`, `memSel`, `extSel`, `memWe` and `rdValid` low.
- R2: While the port is idle (`busy` low), `ptrLoad` high at a clock edge loads `ptrLoadVal` into the pointer. The new value is visible on `memAddr` in the next cycle. A load takes priority over a request sampled in the same cycle, and that request is dropped.
- R3: While `busy` is high, `ptrLoad` is ignored. The pointer takes only its normal transfer update.
- R4: `memAddr` shows the pointer in every cycle and is never undriven or unknown.
- R5: A request (`xferReq` high at an edge while idle) starts a transfer of exactly two cycles, with `busy` and one select high in both cycles. `memWe` is high only in the second cycle and only for a write (`xferWrite`=1). In that cycle `memWrData` equals the `hostWrData` sampled with the request. `busy` falls for at least one cycle before the next request is accepted.
- R6: A linear transfer (`xferExt`=0) asserts `memSel` and adds one to the pointer at the end of its second cycle. 0xFFFFFF wraps to 0x000000.
- R7: On a read, `rdData` takes the value of `memRdData` from the second cycle. `rdValid` pulses high for the one cycle that follows.
- R8: A device transfer (`xferExt`=1) asserts `extSel` instead of `memSel`. It drives `extAddr` = {sub-address in bits 9:5, word number in bits 4:0}, using the values sampled with the request. It leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptrLoad | input | 1 | Load the pointer (honoured only while idle) |
| ptrLoadVal | input | 24 | Value for a pointer load |
| xferReq | input | 1 | Start a transfer |
| xferWrite | input | 1 | 1 = write, 0 = read |
| xferExt | input | 1 | 1 = external device transfer, 0 = linear transfer |
| extSub | input | 5 | Sub-address for a device transfer |
| extWord | input | 5 | Word number for a device transfer |
| hostWrData | input | 16 | Write data captured with the request |
| memRdData | input | 16 | Read data bus from memory or device |
| busy | output | 1 | Transfer in progress |
| memAddr | output | 24 | Linear pointer, always driven (readback) |
| extAddr | output | 10 | Device address {sub, word} |
| memSel | output | 1 | Linear target selected |
| extSel | output | 1 | Device target selected |
| memWe | output | 1 | Write strobe, second cycle only |
| memWrData | output | 16 | Write data bus |
| rdData | output | 16 | Captured read data |
| rdValid | output | 1 | Read data valid pulse |

## Verification
Linear writes and reads run back to back from a loaded pointer. These show whether the step happens after the access, not before it, and whether the write strobe and data stay off the first cycle. Device reads and writes with distinct sub-address and word values check the field order on `extAddr` and that the pointer holds still. A load pulsed in the middle of a transfer, and a read started at 0xFFFFFF, separate an ignored load from a taken one and a wrapping increment from a carry-out. An alternating mixed burst checks that read capture follows the right bus value for each kind of target.

// File: rtl/xport_pkg.sv
package xport_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic loadPtr;
    logic incPtr;
    logic capRead;
  } strobe_t;
endpackage

// File: rtl/xport_ctrl.sv
module xport_ctrl
  import xport_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    xferReq,
  input  logic    xferWrite,
  input  logic    xferExt,
  input  logic    ptrLoad,
  output strobe_t strb,
  output logic    busy,
  output logic    selDma,
  output logic    selExt,
  output logic    weOut
);
  phase_t phase, phaseNext;
  logic   curExt, curWrite;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (!ptrLoad && xferReq) phaseNext = PH_ADDR;
      PH_ADDR: phaseNext = PH_DATA;
      PH_DATA: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      curExt   <= 1'b0;
      curWrite <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (strb.latchReq) begin
        curExt   <= xferExt;
        curWrite <= xferWrite;
      end
    end
  end

  always_comb begin
    strb.loadPtr  = (phase == PH_IDLE) && ptrLoad;
    strb.latchReq = (phase == PH_IDLE) && !ptrLoad && xferReq;
    strb.incPtr   = (phase == PH_DATA) && !curExt;
    strb.capRead  = (phase == PH_DATA) && !curWrite;
    busy          = (phase != PH_IDLE);
    selDma        = busy && !curExt;
    selExt        = busy && curExt;
    weOut         = (phase == PH_DATA) && curWrite;
  end
endmodule

// File: rtl/xport_dpath.sv
module xport_dpath
  import xport_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int SUB_W  = 5,
  parameter int WORD_W = 5,
  localparam int EXT_W = SUB_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  input  logic [SUB_W-1:0]  extSub,
  input  logic [WORD_W-1:0] extWord,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] ptr,
  output logic [EXT_W-1:0]  extAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (strb.loadPtr) ptr <= ptrLoadVal;
    else if (strb.incPtr) ptr <= ptr + ONE;  // natural wrap
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      extAddr <= '0;
      wrData  <= '0;
    end else if (strb.latchReq) begin
      extAddr <= {extSub, extWord};
      wrData  <= hostWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.capRead;
      if (strb.capRead) rdData <= memRdData;
    end
  end
endmodule

// File: rtl/xport.sv
module xport
  import xport_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int SUB_W  = 5,
  parameter int WORD_W = 5,
  localparam int EXT_W = SUB_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  input  logic              xferReq,
  input  logic              xferWrite,
  input  logic              xferExt,
  input  logic [SUB_W-1:0]  extSub,
  input  logic [WORD_W-1:0] extWord,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic [EXT_W-1:0]  extAddr,
  output logic              memSel,
  output logic              extSel,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  strobe_t strb;

  xport_ctrl u_ctrl (
    .clk(clk), .rst(rst), .xferReq(xferReq), .xferWrite(xferWrite),
    .xferExt(xferExt), .ptrLoad(ptrLoad), .strb(strb), .busy(busy),
    .selDma(memSel), .selExt(extSel), .weOut(memWe)
  );

  xport_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_W(SUB_W), .WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .ptrLoadVal(ptrLoadVal),
    .extSub(extSub), .extWord(extWord), .hostWrData(hostWrData),
    .memRdData(memRdData), .ptr(memAddr), .extAddr(extAddr),
    .wrData(memWrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

module xport_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              memSel,
  input logic              extSel,
  input logic              memWe,
  input logic              ptrLoad,
  input logic [ADDR_W-1:0] ptrLoadVal,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rdValid
);
  // R6
  ptr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (memSel && $past(memSel)) |=> (memAddr == $past(memAddr) + ADDR_W'(1)));
  // R8
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
    extSel |=> $stable(memAddr));
  // R8
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(memSel && extSel));
  // R5
  two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |=> busy);
  // R5
  end_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);
  // R5
  we_phase_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (busy && $past(busy)));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (ptrLoad && !busy) |=> (memAddr == $past(ptrLoadVal)));
  // R3
  load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ptrLoad && busy && !(memSel && $past(memSel))) |=> $stable(memAddr));
  // R7
  rdv_chk: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> (!busy && $past(busy)));
endmodule

bind xport xport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .memSel(memSel), .extSel(extSel),
  .memWe(memWe), .ptrLoad(ptrLoad), .ptrLoadVal(ptrLoadVal),
  .memAddr(memAddr), .rdValid(rdValid)
);

// File: tb/xport_tb.sv
module xport_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, ptrLoad, xferReq, xferWrite, xferExt;
  logic [23:0] ptrLoadVal;
  logic [4:0]  extSub, extWord;
  logic [15:0] hostWrData, memRdData;
  logic busy, memSel, extSel, memWe, rdValid;
  logic [23:0] memAddr;
  logic [9:0]  extAddr;
  logic [15:0] memWrData, rdData;

  xport u_dut (.*);

  typedef struct packed {
    logic ext; logic [23:0] a; logic [9:0] e; logic we; logic [15:0] d;
  } busItem_t;

  busItem_t busQ[$];
  logic [15:0] rdQ[$];
  logic [23:0] ptrModel;
  int total = 0, bad = 0;
  bit prevSel = 1'b0;

  function automatic logic [15:0] memFn(logic ext, logic [23:0] a, logic [9:0] e);
    return ext ? ({6'd0, e} ^ 16'h0F0F) : (a[15:0] ^ 16'h5A3C);
  endfunction

  assign memRdData = memSel ? memFn(1'b0, memAddr, extAddr) :
                     extSel ? memFn(1'b1, memAddr, extAddr) : 16'hDEAD;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the port produces them
  always @(negedge clk) begin
    if (rst) prevSel = 1'b0;
    else begin
      bit sel;
      sel = memSel | extSel;
      chk(!$isunknown(memAddr), "R4 addr driven", {8'd0, memAddr}, 32'd0);
      if (sel && !prevSel) chk(!memWe, "R5 no strobe in first cycle", {31'd0, memWe}, 32'd0);
      if (sel && prevSel) begin
        if (busQ.size() == 0) chk(1'b0, "R5 unexpected transfer", 32'd1, 32'd0);
        else begin
          busItem_t it;
          it = busQ.pop_front();
          chk(memAddr == it.a, "R6 address in data cycle", {8'd0, memAddr}, {8'd0, it.a});
          chk(extSel == it.ext && memSel == !it.ext, "R8 select", {30'd0, memSel, extSel},
              {30'd0, !it.ext, it.ext});
          chk(memWe == it.we, "R5 write strobe", {31'd0, memWe}, {31'd0, it.we});
          if (it.we) chk(memWrData == it.d, "R5 write data", {16'd0, memWrData}, {16'd0, it.d});
          if (it.ext) chk(extAddr == it.e, "R8 device address", {22'd0, extAddr}, {22'd0, it.e});
        end
      end
      if (rdValid) begin
        if (rdQ.size() == 0) chk(1'b0, "R7 unexpected rdValid", 32'd1, 32'd0);
        else begin
          logic [15:0] ex;
          ex = rdQ.pop_front();
          chk(rdData == ex, "R7 read data", {16'd0, rdData}, {16'd0, ex});
        end
      end
      prevSel = sel;
    end
  end

  // driver: called at a negedge with the port idle
  task automatic doXfer(bit wr, bit ext, logic [4:0] s, logic [4:0] w,
                        logic [15:0] d, bit loadMid);
    busQ.push_back('{ext: ext, a: ptrModel, e: {s, w}, we: wr, d: d});
    if (!wr) rdQ.push_back(memFn(ext, ptrModel, {s, w}));
    if (!ext) ptrModel = ptrModel + 24'd1;
    xferReq = 1'b1; xferWrite = wr; xferExt = ext;
    extSub = s; extWord = w; hostWrData = d;
    @(negedge clk);
    xferReq = 1'b0; hostWrData = 16'hFFFF; extSub = 5'h1F; extWord = 5'h1F;
    if (loadMid) begin ptrLoad = 1'b1; ptrLoadVal = 24'hABCDEF; end
    @(negedge clk);
    ptrLoad = 1'b0;
    @(negedge clk);
  endtask

  task automatic doLoad(logic [23:0] v);
    ptrLoad = 1'b1; ptrLoadVal = v;
    @(negedge clk);
    ptrLoad = 1'b0;
    ptrModel = v;
    chk(memAddr == v, "R2 load", {8'd0, memAddr}, {8'd0, v});
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ptrLoad = 0; ptrLoadVal = '0; xferReq = 0; xferWrite = 0;
    xferExt = 0; extSub = '0; extWord = '0; hostWrData = '0; ptrModel = '0;
    repeat (3) @(negedge clk);
    chk(memAddr == 24'd0, "R1 pointer reset", {8'd0, memAddr}, 32'd0);
    chk({busy, memSel, extSel, memWe, rdValid} == 5'd0, "R1 outputs idle",
        {27'd0, busy, memSel, extSel, memWe, rdValid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    doLoad(24'h000100);
    doXfer(1, 0, 5'd0, 5'd0, 16'h1234, 0);
    doXfer(0, 0, 5'd0, 5'd0, 16'h0000, 0);
    chk(memAddr == 24'h000102, "R6 two steps", {8'd0, memAddr}, 32'h000102);

    doXfer(1, 1, 5'd3, 5'd17, 16'hBEEF, 0);
    doXfer(0, 1, 5'd31, 5'd0, 16'h0000, 0);
    chk(memAddr == 24'h000102, "R8 pointer unchanged", {8'd0, memAddr}, 32'h000102);

    doXfer(0, 0, 5'd0, 5'd0, 16'h0000, 1);
    chk(memAddr == ptrModel, "R3 load ignored while busy", {8'd0, memAddr}, {8'd0, ptrModel});
    doXfer(1, 1, 5'd5, 5'd9, 16'h7777, 1);
    chk(memAddr == ptrModel, "R3 load ignored in device transfer", {8'd0, memAddr}, {8'd0, ptrModel});

    // load beats a same-cycle request
    xferReq = 1'b1; ptrLoad = 1'b1; ptrLoadVal = 24'h00ABC0;
    @(negedge clk);
    xferReq = 1'b0; ptrLoad = 1'b0; ptrModel = 24'h00ABC0;
    chk(!busy && memAddr == 24'h00ABC0, "R2 load priority", {7'd0, busy, memAddr},
        {8'd0, 24'h00ABC0});
    @(negedge clk);

    doLoad(24'hFFFFFF);
    doXfer(0, 0, 5'd0, 5'd0, 16'h0000, 0);
    chk(memAddr == 24'h000000, "R6 wrap", {8'd0, memAddr}, 32'd0);

    for (int i = 0; i < 8; i++)
      doXfer(i[0], i[1], 5'(i * 3), 5'(31 - i), 16'(16'h1000 + i * 16'h0111), 0);
    chk(memAddr == ptrModel, "R6 burst pointer", {8'd0, memAddr}, {8'd0, ptrModel});

    repeat (3) @(negedge clk);
    chk(busQ.size() == 0, "R5 all transfers seen", busQ.size(), 32'd0);
    chk(rdQ.size() == 0, "R7 all reads seen", rdQ.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule